// File: doc/BRIEF.md
# Four-Channel Phase-Accumulator Clock Bank

This block makes four independent square-wave clocks of programmable frequency. Each channel owns a 32-bit phase accumulator that advances by its tuning word on every cycle where the step enable is high. The step enable averages 40 MHz on a faster fabric clock, so the output frequency is tuning × 40 MHz / 2^32. The clock comes straight from the accumulator's top bit, with no waveform table. The accumulator is meant to cover one octave only. A power-of-two divider after it reaches the lower frequencies and keeps a 50% duty cycle.

Software writes new tuning words and divider exponents into a staging layer through a plain address/data/write-enable port. One install pulse then moves the staged values of every channel into the running layer in the same cycle, so several channels change frequency together. An install leaves the accumulator phase alone and changes only the increment, so the output has no phase jump. A new divider exponent waits for that divider's next terminal count before it takes effect.

Top module: `clk_synth_bank`

## Requirements
- R1: While reset is asserted, and right after it, every accumulator, running tuning word, exponent and divider counter is zero, `clk_out` is all low and `rd_data` reads zero at every address.
- R2: Writing to the staging layer changes neither `clk_out` nor `rd_data` until an install pulse. The address is {channel, select}: select 0 is the tuning word and select 1 is the divider exponent.
- R3: An install pulse copies the staged tuning words and exponents of all channels into the running layer in the same cycle. A write in the same cycle as the install goes to staging only, and it takes effect at the following install.
- R4: On each cycle where `step_en` is high, a channel's accumulator adds its running tuning word modulo 2^32. When `step_en` is low, the accumulator holds its value.
- R5: With exponent 0, `clk_out` of that channel equals the accumulator's most significant bit, and it changes at the same clock edge as the accumulator.
- R6: With exponent n > 0, `clk_out` toggles on every 2^(n-1)-th rising edge of the accumulator MSB. This gives a 50% duty cycle and 2^n MSB periods per output period.
- R7: An install does not clear or jump the accumulator. The phase continues from its current value with the new increment.
- R8: A divider takes up its newly installed exponent only at its terminal count. Under exponent 0 the terminal count is any MSB rising edge. Otherwise it is the rising edge on which the half-period counter is at its last value. At that moment the counter clears, and the divided output goes high if the old exponent was 0 and toggles if it was not.
- R9: A tuning write above 0x6000_0000 (15 MHz at a 40 MHz step rate) is stored as 0x6000_0000.
- R10: An exponent write stores only bits [3:0] of `wr_data`.
- R11: `rd_data` is combinational from `rd_addr` and returns the running (installed) value, zero-extended for exponents, and never the staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Accumulator advance enable, 40 MHz average rate |
| wr_en | input | 1 | Staging write strobe |
| wr_addr | input | 3 | Write address {channel[1:0], select} |
| wr_data | input | 32 | Write data |
| install | input | 1 | Moves all staged values to the running layer |
| rd_addr | input | 3 | Read address {channel[1:0], select} |
| rd_data | output | 32 | Running value at `rd_addr` |
| clk_out | output | 4 | Synthesized clocks, one bit per channel |

## Verification
The assertions check on every cycle the properties that hold at any single edge. These are: the running layer stays the same without an install, accumulators, exponents and outputs hold still without a step, the tuning cap is never exceeded, and the divider counter stays inside the half-period for its exponent. The bench's scenarios are the only evidence for the cycle-exact waveform. That covers the phase continuing across installs, the divided periods, exponent changes landing exactly at the terminal count, the cap and exponent truncation seen at the read port, and a write racing an install. The bench compares all of these against a reference model it builds from the requirements.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

    // select bit at the bottom of every register address
    typedef enum logic {
        SEL_TUNE = 1'b0,
        SEL_EXP  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/synth_regs.sv
module synth_regs
    import clk_synth_pkg::*;
#(
    parameter int          NCH      = 4,
    parameter int          ACC_W    = 32,
    parameter int          EXP_W    = 4,
    parameter logic [31:0] TUNE_MAX = 32'h6000_0000,
    localparam int         CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int         ADDR_W   = CH_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [ACC_W-1:0]               wr_data,
    input  logic                           install,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [ACC_W-1:0]               rd_data,
    output logic [NCH-1:0][ACC_W-1:0]      tune_run,
    output logic [NCH-1:0][EXP_W-1:0]      exp_run
);

    localparam logic [ACC_W-1:0] CAP = ACC_W'(TUNE_MAX);

    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0] stg_tune;
        logic [NCH-1:0][EXP_W-1:0] stg_exp;
        logic [NCH-1:0][ACC_W-1:0] run_tune;
        logic [NCH-1:0][EXP_W-1:0] run_exp;
    } regs_t;

    regs_t s_d, s_q;

    logic [ACC_W-1:0] wr_tune_capped;
    reg_sel_e         wr_sel, rd_sel;

    always_comb begin
        s_d            = s_q;
        wr_sel         = reg_sel_e'(wr_addr[0]);
        wr_tune_capped = (wr_data > CAP) ? CAP : wr_data;

        // install reads the staging layer as it stood before this edge
        if (install) begin
            s_d.run_tune = s_q.stg_tune;
            s_d.run_exp  = s_q.stg_exp;
        end

        if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr[ADDR_W-1:1] == CH_W'(i)) begin
                    if (wr_sel == SEL_TUNE) s_d.stg_tune[i] = wr_tune_capped;
                    else                    s_d.stg_exp[i]  = wr_data[EXP_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        rd_sel  = reg_sel_e'(rd_addr[0]);
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr[ADDR_W-1:1] == CH_W'(i)) begin
                if (rd_sel == SEL_TUNE) rd_data = s_q.run_tune[i];
                else                    rd_data = ACC_W'(s_q.run_exp[i]);
            end
        end
    end

    assign tune_run = s_q.run_tune;
    assign exp_run  = s_q.run_exp;

    // running layer moves only on install
    assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !install |=> ($stable(tune_run) && $stable(exp_run)));

    for (genvar g = 0; g < NCH; g++) begin : g_cap
        assert_tune_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.stg_tune[g] <= CAP) && (tune_run[g] <= CAP));
    end

endmodule

// File: rtl/synth_chan.sv
module synth_chan #(
    parameter int  ACC_W = 32,
    parameter int  EXP_W = 4,
    localparam int CNT_W = (1 << EXP_W) - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [ACC_W-1:0] tune,
    input  logic [EXP_W-1:0] exp_new,
    output logic             clk_out
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [EXP_W-1:0] expo;
        logic             div;
    } chan_t;

    chan_t s_d, s_q;

    logic [ACC_W-1:0] sum;
    logic             msb_rise;
    logic [CNT_W-1:0] half_last;
    logic [31:0]      half_wide;

    always_comb begin
        // last count value of one half period: 2^(e-1) - 1
        half_wide = (s_q.expo == '0) ? 32'd0
                  : (32'd1 << (s_q.expo - EXP_W'(1))) - 32'd1;
        half_last = half_wide[CNT_W-1:0];
    end

    always_comb begin
        s_d      = s_q;
        sum      = s_q.acc + tune;
        msb_rise = ~s_q.acc[ACC_W-1] & sum[ACC_W-1];

        if (step_en) begin
            s_d.acc = sum;
            if (msb_rise) begin
                if ((s_q.expo == '0) || (s_q.cnt == half_last)) begin
                    s_d.cnt  = '0;
                    s_d.expo = exp_new;
                    s_d.div  = (s_q.expo == '0) ? 1'b1 : ~s_q.div;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_out = (s_q.expo == '0) ? s_q.acc[ACC_W-1] : s_q.div;

    assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(s_q.acc));

    assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.expo == '0) |-> (s_q.cnt == '0));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.expo != '0) |-> (s_q.cnt <= half_last));

    assert_swap_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(s_q.expo) && $stable(clk_out)));

endmodule

// File: rtl/clk_synth_bank.sv
module clk_synth_bank #(
    parameter int          NCH      = 4,
    parameter int          ACC_W    = 32,
    parameter int          EXP_W    = 4,
    parameter logic [31:0] TUNE_MAX = 32'h6000_0000,
    localparam int         CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int         ADDR_W   = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic              install,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ACC_W-1:0]  rd_data,
    output logic [NCH-1:0]    clk_out
);

    logic [NCH-1:0][ACC_W-1:0] tune_run;
    logic [NCH-1:0][EXP_W-1:0] exp_run;

    synth_regs #(
        .NCH      (NCH),
        .ACC_W    (ACC_W),
        .EXP_W    (EXP_W),
        .TUNE_MAX (TUNE_MAX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .install  (install),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .tune_run (tune_run),
        .exp_run  (exp_run)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        synth_chan #(
            .ACC_W (ACC_W),
            .EXP_W (EXP_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (step_en),
            .tune    (tune_run[g]),
            .exp_new (exp_run[g]),
            .clk_out (clk_out[g])
        );
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |-> (clk_out == '0));

endmodule

// File: tb/sim_clk_synth_bank.sv
`timescale 1ns/1ps
module sim_clk_synth_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        install = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  clk_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clk_synth_bank u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .install(install),
        .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
    );

    // ---------------- reference model built from the requirements
    logic [31:0] m_stg_t [4];
    logic [3:0]  m_stg_e [4];
    logic [31:0] m_tune  [4];
    logic [3:0]  m_einst [4];
    logic [31:0] m_acc   [4];
    int          m_cnt   [4];
    logic [3:0]  m_exp   [4];
    logic        m_div   [4];

    function automatic logic [31:0] cap_tune(input logic [31:0] d);
        return (d > 32'h6000_0000) ? 32'h6000_0000 : d;   // R9
    endfunction

    function automatic logic exp_clk(input int ch);
        return (m_exp[ch] == 4'd0) ? m_acc[ch][31] : m_div[ch];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        return a[0] ? {28'd0, m_einst[a[2:1]]} : m_tune[a[2:1]];  // R10 R11
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_stg_t[i] <= '0; m_stg_e[i] <= '0; m_tune[i] <= '0;
                m_einst[i] <= '0; m_acc[i] <= '0; m_cnt[i] <= 0;
                m_exp[i] <= '0; m_div[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] nx;
                nx = m_acc[i] + m_tune[i];
                if (step_en) begin
                    m_acc[i] <= nx;
                    if (!m_acc[i][31] && nx[31]) begin
                        if (m_exp[i] == 0 || m_cnt[i] == (1 << (m_exp[i] - 1)) - 1) begin
                            m_cnt[i] <= 0;
                            m_exp[i] <= m_einst[i];
                            m_div[i] <= (m_exp[i] == 0) ? 1'b1 : ~m_div[i];
                        end else begin
                            m_cnt[i] <= m_cnt[i] + 1;
                        end
                    end
                end
                if (install) begin
                    m_tune[i]  <= m_stg_t[i];
                    m_einst[i] <= m_stg_e[i];
                end
            end
            if (wr_en) begin
                if (wr_addr[0]) m_stg_e[wr_addr[2:1]] <= wr_data[3:0];
                else            m_stg_t[wr_addr[2:1]] <= cap_tune(wr_data);
            end
        end
    end

    // ---------------- checking
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model: R4 accumulation, R5/R6 output
    // shape, R7 phase continuity after installs, R8 exponent swap timing
    always @(negedge clk) begin
        if (chk_on && !done) begin
            for (int i = 0; i < 4; i++)
                chk("R4/R5/R6/R7/R8 clk_out", {31'd0, clk_out[i]}, {31'd0, exp_clk(i)});
            chk("R11 rd_data", rd_data, exp_rd(rd_addr));
        end
    end

    // step enable: 8 of every 25 fabric cycles, 40 MHz average
    int st = 0;
    always @(posedge clk) begin
        #1;
        st = st + 8;
        if (st >= 25) begin st = st - 25; step_en = 1'b1; end
        else step_en = 1'b0;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            rd_addr = 3'($urandom_range(0, 7));
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_install();
        @(posedge clk); #1;
        install = 1'b1;
        @(posedge clk); #1;
        install = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        void'($urandom(32'd20241207));

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 clk_out in reset", {28'd0, clk_out}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); #1;
            chk("R1 rd_data in reset", rd_data, 32'd0);
        end
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 clk_out after reset", {28'd0, clk_out}, 32'd0);
        chk_on = 1'b1;

        // R2: staged values do not reach outputs or readback
        wr(3'b000, 32'h4000_0000);
        wr(3'b001, 32'd0);
        wr(3'b010, 32'h3000_0000);
        wr(3'b011, 32'd1);
        wr(3'b110, 32'hFFFF_FFFF);             // R9 above cap
        wr(3'b111, 32'hFFFF_FFF2);             // R10 upper bits dropped
        wr(3'b100, 32'h5555_5555);
        wr(3'b101, 32'd3);
        run(40);
        chk("R2 clk_out before install", {28'd0, clk_out}, 32'd0);
        rd_chk("R2 readback before install", 3'b000, 32'd0);
        rd_chk("R2 readback before install", 3'b111, 32'd0);

        // R3: install moves all channels at once
        do_install();
        rd_chk("R3 ch0 tune", 3'b000, 32'h4000_0000);
        rd_chk("R3 ch1 tune", 3'b010, 32'h3000_0000);
        rd_chk("R3 ch1 exp",  3'b011, 32'd1);
        rd_chk("R9 ch3 capped tune", 3'b110, 32'h6000_0000);
        rd_chk("R10 ch3 exp truncated", 3'b111, 32'd2);
        rd_chk("R3 ch2 exp", 3'b101, 32'd3);
        run(600);

        // R3: a write coinciding with install is staged only
        wr(3'b000, 32'h2000_0000);
        @(posedge clk); #1;
        install = 1'b1; wr_en = 1'b1; wr_addr = 3'b000; wr_data = 32'h5000_0000;
        @(posedge clk); #1;
        install = 1'b0; wr_en = 1'b0;
        rd_chk("R3 same-cycle write not installed", 3'b000, 32'h2000_0000);
        run(200);
        do_install();
        rd_chk("R3 same-cycle write at next install", 3'b000, 32'h5000_0000);

        // R8: exponent changes from 0 and back
        wr(3'b001, 32'd2);
        do_install();
        run(300);
        wr(3'b001, 32'd0);
        do_install();
        run(300);

        // random phase: retune and re-divide, checked every cycle by the model
        for (int r = 0; r < 45; r++) begin
            int nw;
            nw = $urandom_range(1, 6);
            for (int k = 0; k < nw; k++) begin
                logic [2:0] a;
                a = 3'($urandom_range(0, 7));
                if (a[0]) wr(a, $urandom_range(0, 4) | ($urandom() & 32'hFFF0_0000));
                else      wr(a, $urandom_range(32'h1800_0000, 32'h7000_0000));
            end
            do_install();
            run($urandom_range(150, 1500));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule